// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard-control logic of a five-stage in-order integer pipeline: fetch, decode, execute, memory access and writeback. Each cycle the decode stage presents the register numbers and kind of the instruction it holds. The controller carries that information through its own copies of the execute, memory and writeback stage records. It also keeps one more record for the instruction that retired on the last clock edge. From these records it produces the operand bypass selects for the execute stage, a stall that freezes fetch and decode, and a bubble request for the execute stage.

Register-file and data-memory writes take effect on the rising clock edge. An operand read in decode can therefore miss a value written by an instruction that leaves writeback while the reader is still in decode. A fourth bypass source, the retired value, covers that case. Loaded data becomes available at the end of the memory stage. A consumer directly behind a load is therefore held for one cycle and then takes the value from writeback.

Branches resolve in execute, using the same bypassed operands as any other instruction. They have two delay slots. The redirect is raised while the branch sits in execute. The two valid instructions that follow it always complete, and the controller flags each of them as a delay slot when it reaches execute.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset, with no valid instruction in decode, every bypass select is 0, and stall, bubble, redirect and the delay-slot flag are all low.
- R2: The bypass select of an execute-stage operand is 1 when the instruction one stage ahead (memory) writes that register. This source wins over all older sources.
- R3: If the memory stage does not match, select 2 picks the writeback-stage writer, then select 3 picks the instruction retired on the last edge, and otherwise the select is 0 (register file).
- R4: Register 0 is never bypassed (select 0) and never causes a stall.
- R5: When a decode instruction uses a register that the load in execute writes, stall and bubble are both high in that same cycle. Once the load reaches writeback, the consumer in execute gets select 2.
- R6: During a stall the decode instruction is held, and the following cycle has an empty execute stage: no bypass, no redirect and no delay-slot flag for it.
- R7: The redirect is high exactly while a valid branch is in execute and the branch condition input is high. It is never high together with stall.
- R8: The next two valid instructions to reach execute after a branch have the delay-slot flag high, whether or not the branch was taken. Bubbles are not counted, and the slots are never cancelled: their results are still bypassed.
- R9: A branch in decode that reads a register written by the load in execute stalls like any other consumer, and then uses the bypassed operand.
- R10: A source whose use flag is low never selects a bypass and never stalls.
- R11: An instruction whose write-enable flag is low is never a bypass source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_src1_i | input | 5 | First source register number |
| id_src2_i | input | 5 | Second source register number |
| id_use1_i | input | 1 | First source is read |
| id_use2_i | input | 1 | Second source is read |
| id_dst_i | input | 5 | Destination register number |
| id_wen_i | input | 1 | Instruction writes its destination |
| id_load_i | input | 1 | Instruction is a load |
| id_branch_i | input | 1 | Instruction is a branch |
| ex_cond_true_i | input | 1 | Branch comparison result for the execute-stage instruction |
| fwd_a_o | output | 2 | Bypass select, operand 1 (0 file, 1 memory, 2 writeback, 3 retired) |
| fwd_b_o | output | 2 | Bypass select, operand 2 (same encoding) |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| ex_bubble_o | output | 1 | Load a no-op into execute at the next edge |
| redirect_o | output | 1 | Taken branch in execute, steer fetch |
| ex_dslot_o | output | 1 | Execute-stage instruction is a branch delay slot |

## Verification
Stall, bubble and redirect are combinational functions of the current decode inputs and the registered stage records. They are due in the same cycle the decode inputs are applied. A writer's effect on the bypass selects appears one, two and three cycles after it enters execute (select 1, 2, 3). The delay-slot flag appears in the cycle the slot instruction occupies execute. The bench drives inputs on the falling edge and compares all six outputs 1 ns later against its stage model. It then advances that model to mirror the coming rising edge, so every expectation is matched to the cycle in which it is due.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int unsigned HZ_RW = 5;

    typedef logic [HZ_RW-1:0] regnum_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MEM = 2'b01,
        SEL_WB  = 2'b10,
        SEL_RET = 2'b11
    } fwd_sel_e;

    // record of the instruction in execute
    typedef struct packed {
        logic    valid;
        regnum_t src1;
        regnum_t src2;
        logic    use1;
        logic    use2;
        regnum_t dst;
        logic    wen;
        logic    load;
        logic    branch;
    } ex_rec_t;

    // record of a writer in memory, writeback or retired position
    typedef struct packed {
        logic    valid;
        regnum_t dst;
        logic    wen;
        logic    load;
    } wr_rec_t;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  regnum_t  src,
    input  logic     src_used,
    input  wr_rec_t  mem_rec,
    input  wr_rec_t  wb_rec,
    input  wr_rec_t  ret_rec,
    output fwd_sel_e sel
);
    function automatic logic writes(input wr_rec_t r, input regnum_t s);
        return r.valid && r.wen && (r.dst == s);
    endfunction

    always_comb begin
        sel = SEL_RF;
        if (src_used && (src != '0)) begin
            if (writes(mem_rec, src))      sel = SEL_MEM;
            else if (writes(wb_rec, src))  sel = SEL_WB;
            else if (writes(ret_rec, src)) sel = SEL_RET;
        end
    end

    assert_zero_not_bypassed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SEL_RF));
    assert_unused_not_bypassed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !src_used |-> (sel == SEL_RF));
    assert_load_never_from_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MEM) |-> !mem_rec.load);
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse
    import hz_pkg::*;
(
    input  logic    id_valid,
    input  regnum_t id_src1,
    input  regnum_t id_src2,
    input  logic    id_use1,
    input  logic    id_use2,
    input  ex_rec_t ex_rec,
    output logic    hazard
);
    logic ld_live;
    logic hit1, hit2;

    always_comb begin
        ld_live = ex_rec.valid && ex_rec.load && ex_rec.wen && (ex_rec.dst != '0);
        hit1    = id_use1 && (id_src1 == ex_rec.dst);
        hit2    = id_use2 && (id_src2 == ex_rec.dst);
        hazard  = id_valid && ld_live && (hit1 || hit2);
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned DELAY_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 id_valid_i,
    input  logic [HZ_RW-1:0]     id_src1_i,
    input  logic [HZ_RW-1:0]     id_src2_i,
    input  logic                 id_use1_i,
    input  logic                 id_use2_i,
    input  logic [HZ_RW-1:0]     id_dst_i,
    input  logic                 id_wen_i,
    input  logic                 id_load_i,
    input  logic                 id_branch_i,
    input  logic                 ex_cond_true_i,
    output logic [1:0]           fwd_a_o,
    output logic [1:0]           fwd_b_o,
    output logic                 stall_o,
    output logic                 ex_bubble_o,
    output logic                 redirect_o,
    output logic                 ex_dslot_o
);
    localparam int unsigned NOPS = 2;
    localparam int unsigned CW   = $clog2(DELAY_SLOTS + 1);

    typedef struct packed {
        ex_rec_t         ex;
        wr_rec_t         mem;
        wr_rec_t         wb;
        wr_rec_t         ret;
        logic [CW-1:0]   pend;
        logic            dslot;
    } state_t;

    state_t   st_d, st_q;
    logic     hazard;
    logic     enter;
    regnum_t  op_src  [NOPS];
    logic     op_used [NOPS];
    fwd_sel_e op_sel  [NOPS];

    always_comb begin
        op_src[0]  = st_q.ex.src1;
        op_src[1]  = st_q.ex.src2;
        op_used[0] = st_q.ex.valid && st_q.ex.use1;
        op_used[1] = st_q.ex.valid && st_q.ex.use2;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_fwd_sel u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (op_src[g]),
            .src_used (op_used[g]),
            .mem_rec  (st_q.mem),
            .wb_rec   (st_q.wb),
            .ret_rec  (st_q.ret),
            .sel      (op_sel[g])
        );
    end

    hz_loaduse u_lu (
        .id_valid (id_valid_i),
        .id_src1  (id_src1_i),
        .id_src2  (id_src2_i),
        .id_use1  (id_use1_i),
        .id_use2  (id_use2_i),
        .ex_rec   (st_q.ex),
        .hazard   (hazard)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ret = st_q.wb;
        st_d.wb  = st_q.mem;
        st_d.mem = '{valid: st_q.ex.valid, dst: st_q.ex.dst,
                     wen:   st_q.ex.wen,   load: st_q.ex.load};
        enter    = id_valid_i && !hazard;
        st_d.ex  = '0;
        st_d.dslot = 1'b0;
        if (enter) begin
            st_d.ex = '{valid: 1'b1, src1: id_src1_i, src2: id_src2_i,
                        use1: id_use1_i, use2: id_use2_i, dst: id_dst_i,
                        wen: id_wen_i, load: id_load_i, branch: id_branch_i};
            st_d.dslot = (st_q.pend != '0);
            if (id_branch_i)          st_d.pend = CW'(DELAY_SLOTS);
            else if (st_q.pend != '0) st_d.pend = st_q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_a_o     = op_sel[0];
    assign fwd_b_o     = op_sel[1];
    assign stall_o     = hazard;
    assign ex_bubble_o = hazard;
    assign redirect_o  = st_q.ex.valid && st_q.ex.branch && ex_cond_true_i;
    assign ex_dslot_o  = st_q.dslot;

    assert_bubble_empties_ex_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (!redirect_o && !ex_dslot_o && fwd_a_o == 2'b00 && fwd_b_o == 2'b00));
    assert_redirect_without_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !stall_o);
    assert_first_slot_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ex.valid && st_q.ex.branch && id_valid_i && !stall_o) |=> ex_dslot_o);
    assert_zero_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ex.dst == '0) |-> !stall_o);
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid, id_use1, id_use2, id_wen, id_load, id_branch, cond;
    logic [4:0] id_src1, id_src2, id_dst;
    logic [1:0] fwd_a, fwd_b;
    logic       stall, bubble, redirect, dslot;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hazard_ctrl i_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid),
        .id_src1_i(id_src1), .id_src2_i(id_src2), .id_use1_i(id_use1),
        .id_use2_i(id_use2), .id_dst_i(id_dst), .id_wen_i(id_wen),
        .id_load_i(id_load), .id_branch_i(id_branch), .ex_cond_true_i(cond),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall),
        .ex_bubble_o(bubble), .redirect_o(redirect), .ex_dslot_o(dslot)
    );

    // bench model of the stage records
    bit       e_v, e_u1, e_u2, e_w, e_l, e_b;
    bit [4:0] e_s1, e_s2, e_d;
    bit       m_v, m_w, m_l, w_v, w_w, r_v, r_w;
    bit [4:0] m_d, w_d, r_d;
    int       pend;
    bit       ds;

    task automatic model_reset();
        {e_v, e_u1, e_u2, e_w, e_l, e_b} = '0;
        {m_v, m_w, m_l, w_v, w_w, r_v, r_w} = '0;
        pend = 0; ds = 0;
    endtask

    function automatic bit [1:0] exp_sel(bit [4:0] s, bit u);
        if (!u || s == 0)                return 2'd0;
        if (m_v && m_w && m_d == s)      return 2'd1;
        if (w_v && w_w && w_d == s)      return 2'd2;
        if (r_v && r_w && r_d == s)      return 2'd3;
        return 2'd0;
    endfunction

    function automatic bit exp_stall();
        bit ld = e_v && e_l && e_w && e_d != 0;
        return id_valid && ld && ((id_use1 && id_src1 == e_d) || (id_use2 && id_src2 == e_d));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare at the current moment, then advance the model to the next edge
    function automatic string pick(string tag, string dflt);
        return (tag == "") ? dflt : tag;
    endfunction

    task automatic check_and_advance(string tag, output bit st);
        bit ent;
        st = exp_stall();
        chk(pick(tag, "R2"), "fwd_a", fwd_a, exp_sel(e_s1, e_v && e_u1));
        chk(pick(tag, "R3"), "fwd_b", fwd_b, exp_sel(e_s2, e_v && e_u2));
        chk(pick(tag, "R5"), "stall", stall, st);
        chk(pick(tag, "R6"), "bubble", bubble, st);
        chk(pick(tag, "R7"), "redirect", redirect, e_v && e_b && cond);
        chk(pick(tag, "R8"), "dslot", dslot, ds);
        r_v = w_v; r_d = w_d; r_w = w_w;
        w_v = m_v; w_d = m_d; w_w = m_w;
        m_v = e_v; m_d = e_d; m_w = e_w; m_l = e_l;
        ent = id_valid && !st;
        ds  = 0;
        if (ent) begin
            {e_v, e_s1, e_s2, e_u1, e_u2, e_d, e_w, e_l, e_b} =
                {1'b1, id_src1, id_src2, id_use1, id_use2, id_dst, id_wen, id_load, id_branch};
            ds = (pend != 0);
            if (id_branch) pend = 2;
            else if (pend != 0) pend = pend - 1;
        end else begin
            {e_v, e_u1, e_u2, e_w, e_l, e_b} = '0;
        end
    endtask

    // present one instruction at decode (called at a falling edge), repeat while stalled
    task automatic issue(string tag, bit v, bit [4:0] s1, bit u1, bit [4:0] s2, bit u2,
                         bit [4:0] d, bit w, bit l, bit b, bit t);
        bit again;
        do begin
            id_valid = v; id_src1 = s1; id_use1 = u1; id_src2 = s2; id_use2 = u2;
            id_dst = d; id_wen = w; id_load = l; id_branch = b; cond = t;
            #1;
            check_and_advance(tag, again);
            @(negedge clk);
        end while (again);
    endtask

    task automatic nop(string tag);
        issue(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        {id_valid, id_use1, id_use2, id_wen, id_load, id_branch, cond} = '0;
        {id_src1, id_src2, id_dst} = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        nop("R1");
        nop("R1");
        // R2: memory-stage bypass, and its priority over an older writer
        issue("R2", 1, 0, 0, 0, 0, 2, 1, 0, 0, 0);
        issue("R2", 1, 2, 1, 0, 0, 3, 1, 0, 0, 0);
        issue("R2", 1, 0, 0, 0, 0, 4, 1, 0, 0, 0);
        issue("R2", 1, 0, 0, 0, 0, 4, 1, 0, 0, 0);
        issue("R2", 1, 4, 1, 4, 1, 0, 0, 0, 0, 0);
        nop("R2"); nop("R2");
        // R3: writeback and retired sources
        issue("R3", 1, 0, 0, 0, 0, 7, 1, 0, 0, 0);
        nop("R3");
        issue("R3", 1, 7, 1, 0, 0, 0, 0, 0, 0, 0);
        issue("R3", 1, 0, 0, 0, 0, 8, 1, 0, 0, 0);
        nop("R3"); nop("R3");
        issue("R3", 1, 0, 0, 8, 1, 0, 0, 0, 0, 0);
        nop("R3"); nop("R3"); nop("R3");
        // R4: register zero neither bypassed nor stalling
        issue("R4", 1, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        issue("R4", 1, 0, 1, 0, 1, 5, 1, 0, 0, 0);
        nop("R4");
        // R5 and R6: load-use stall, bubble, then writeback bypass
        issue("R5", 1, 0, 0, 0, 0, 9, 1, 1, 0, 0);
        issue("R6", 1, 1, 0, 9, 1, 10, 1, 0, 0, 0);
        nop("R5"); nop("R5");
        // R9: branch reading a freshly loaded register, then R7 redirect and R8 slots
        issue("R9", 1, 0, 0, 0, 0, 11, 1, 1, 0, 0);
        issue("R9", 1, 11, 1, 0, 0, 0, 0, 0, 1, 0);
        issue("R7", 1, 0, 0, 0, 0, 12, 1, 0, 0, 1);
        issue("R8", 1, 12, 1, 0, 0, 13, 1, 0, 0, 0);
        issue("R8", 1, 13, 1, 12, 1, 0, 0, 0, 0, 0);
        nop("R8"); nop("R8");
        // R8: untaken branch, bubble between the two slots is not counted
        issue("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        issue("R8", 1, 0, 0, 0, 0, 14, 1, 1, 0, 0);
        issue("R8", 1, 14, 1, 0, 0, 15, 1, 0, 0, 0);
        issue("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        nop("R8"); nop("R8");
        // R10: unused source ignored
        issue("R10", 1, 0, 0, 0, 0, 16, 1, 1, 0, 0);
        issue("R10", 1, 16, 0, 16, 0, 0, 0, 0, 0, 0);
        nop("R10");
        // R11: non-writing instruction is no bypass source
        issue("R11", 1, 0, 0, 0, 0, 17, 0, 0, 0, 0);
        issue("R11", 1, 17, 1, 17, 1, 0, 0, 0, 0, 0);
        nop("R11"); nop("R11");
        // constrained random traffic over a small register range
        for (int i = 0; i < 1500; i++) begin
            bit b = ($urandom % 6) == 0;
            bit l = !b && (($urandom % 4) == 0);
            bit w = !b && (($urandom % 4) != 0);
            issue("", ($urandom % 8) != 0,
                  5'($urandom % 4), 1'($urandom), 5'($urandom % 4), 1'($urandom),
                  5'($urandom % 4), w, l, b, 1'($urandom));
        end
        summary();
        $finish;
    end
endmodule